// File: doc/BRIEF.md
# Clock Power-Down Sequencer

This block takes a set of clock domains into a low-power state, and brings them back out, when an asynchronous active-low request arrives. The request is first resynchronized to the reference clock. The sequencer then closes a gate on every domain output. Each gate closes only while its source clock is low, so the output stops low and never emits a shortened pulse. After every gate reports that its output is held low, the sequencer drops the oscillator and VCO enables.

When the request is released, the oscillator enable rises first and the VCO enable follows one cycle later. A settle counter then runs, and the gates reopen only when it expires. Each gate also reopens only while its source is low, so the first pulse on every output is a whole one.

All logic runs on the reference clock. The domain clocks are treated as slower signals that this clock samples, and each gated output is a registered copy of its source. Every domain has a local stop input, which the sequencer honours only while it is running normally.

Top module: `clk_pwrdn_seq`

## Requirements
- R1: The request passes through a two-stage synchronizer on the reference clock. The enables do not fall within two reference cycles of the request falling. The oscillator enable rises on the third reference edge after the request rises.
- R2: Gated outputs never carry a runt pulse. Every high pulse on output bit d lasts exactly as long as a whole high phase of input bit d, and each rising edge of an output follows a rising edge of its input.
- R3: The oscillator and VCO enables fall together, and only after every domain output has been held low for at least one cycle.
- R4: While the oscillator enable is low, every domain output is low. No domain is exempt.
- R5: On exit the VCO enable rises one cycle after the oscillator enable. The VCO enable is never high while the oscillator enable is low.
- R6: After the oscillator enable rises, all outputs stay low for at least SETTLE_CYC cycles. They resume within SETTLE_CYC plus two periods of the slowest domain plus a few cycles.
- R7: While the sequencer is running, dom_stop_i[d]=1 stops output bit d low without a runt pulse, and the other bits keep running. During power-down the stop inputs have no effect on the outputs or on the enables.
- R8: If the request falls again during the settle interval, the sequencer returns to power-down and no output pulse appears in between.
- R9: Synchronous reset (rst_i=1) drives all outputs low and both enables high. After reset the block passes through the full settle interval before any output toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock, which samples the domain clocks |
| rst_i | input | 1 | Synchronous active-high reset |
| pd_req_n_i | input | 1 | Asynchronous power-down request, active low |
| dom_clk_i | input | N_DOM | Source clock of each domain |
| dom_stop_i | input | N_DOM | Local stop for each domain, active high, honoured only while running |
| dom_clk_o | output | N_DOM | Gated domain clocks, registered |
| osc_en_o | output | 1 | Oscillator enable |
| vco_en_o | output | 1 | VCO enable |

## Verification
Two events can land in the same cycle: power-down gating of a domain and a change of that domain's local stop input. The bench raises every stop bit while the block is powered down and releases them before the wake-up. It then judges the result through the enable sequence, which a scoreboard queue checks, and through the width of every output pulse. The second overlap is a new request arriving while the settle counter is still running. For that case the bench compares the per-domain rising-edge counts taken before and after the aborted wake-up.

// File: rtl/cpd_pkg.sv
package cpd_pkg;
  typedef enum logic [1:0] {
    ST_RUN         = 2'd0,
    ST_GATE_OFF    = 2'd1,
    ST_OSC_OFF     = 2'd2,
    ST_WAKE_SETTLE = 2'd3
  } cpd_state_e;
endpackage

// File: rtl/cpd_sync.sv
module cpd_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) sh_q <= {STAGES{RST_VAL}};
    else       sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/cpd_gate.sv
module cpd_gate (
  input  logic clk_i,
  input  logic rst_i,
  input  logic src_i,
  input  logic allow_i,
  output logic clk_o,
  output logic off_o
);
  logic en_q;
  logic out_q;

  // The enable changes only while the source is low, so pulses stay whole.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      en_q  <= 1'b0;
      out_q <= 1'b0;
    end else begin
      if (!src_i) en_q <= allow_i;
      out_q <= src_i & en_q;
    end
  end

  assign clk_o = out_q;
  assign off_o = !en_q && !out_q;
endmodule

// File: rtl/cpd_settle.sv
module cpd_settle #(
  parameter int CYC = 64
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || !run_i) cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + CW'(1);
  end

  assign done_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/clk_pwrdn_seq.sv
module clk_pwrdn_seq
  import cpd_pkg::*;
#(
  parameter int N_DOM       = 4,
  parameter int SETTLE_CYC  = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             pd_req_n_i,
  input  logic [N_DOM-1:0] dom_clk_i,
  input  logic [N_DOM-1:0] dom_stop_i,
  output logic [N_DOM-1:0] dom_clk_o,
  output logic             osc_en_o,
  output logic             vco_en_o
);
  logic             req_run;
  logic             settle_done;
  logic [N_DOM-1:0] gate_off;
  logic [N_DOM-1:0] allow;
  logic             all_off;
  cpd_state_e       st_q, st_d;
  logic             osc_q, vco_q;

  cpd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i(clk_i), .rst_i(rst_i), .d_i(pd_req_n_i), .q_o(req_run)
  );

  cpd_settle #(.CYC(SETTLE_CYC)) u_settle (
    .clk_i(clk_i), .rst_i(rst_i),
    .run_i(st_q == ST_WAKE_SETTLE), .done_o(settle_done)
  );

  for (genvar g = 0; g < N_DOM; g++) begin : g_dom
    assign allow[g] = (st_q == ST_RUN) && !dom_stop_i[g];
    cpd_gate u_gate (
      .clk_i(clk_i), .rst_i(rst_i), .src_i(dom_clk_i[g]),
      .allow_i(allow[g]), .clk_o(dom_clk_o[g]), .off_o(gate_off[g])
    );
  end

  assign all_off = &gate_off;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_RUN:         if (!req_run) st_d = ST_GATE_OFF;
      ST_GATE_OFF:    if (all_off) st_d = ST_OSC_OFF;
      ST_OSC_OFF:     if (req_run) st_d = ST_WAKE_SETTLE;
      ST_WAKE_SETTLE: begin
        if (!req_run)        st_d = ST_GATE_OFF;
        else if (settle_done) st_d = ST_RUN;
      end
      default:        st_d = ST_GATE_OFF;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st_q  <= ST_WAKE_SETTLE;
      osc_q <= 1'b1;
      vco_q <= 1'b1;
    end else begin
      st_q  <= st_d;
      osc_q <= (st_d != ST_OSC_OFF);
      vco_q <= (st_d != ST_OSC_OFF) && osc_q;
    end
  end

  assign osc_en_o = osc_q;
  assign vco_en_o = vco_q;
endmodule

// File: rtl/clk_pwrdn_seq_chk.sv
module clk_pwrdn_seq_chk #(
  parameter int N_DOM      = 4,
  parameter int SETTLE_CYC = 64
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             pd_req_n_i,
  input logic [N_DOM-1:0] dom_clk_i,
  input logic [N_DOM-1:0] dom_clk_o,
  input logic             osc_en_o,
  input logic             vco_en_o
);
  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam logic [SW-1:0] SMAX = SW'(SETTLE_CYC);

  logic [SW-1:0] since_wake;

  always_ff @(posedge clk_i) begin
    if (rst_i || !osc_en_o) since_wake <= '0;
    else if (since_wake != SMAX) since_wake <= since_wake + SW'(1);
  end

  AST_WAKE_AFTER_SYNC: assert property (@(posedge clk_i) disable iff (rst_i) $rose(osc_en_o) |-> $past(pd_req_n_i, 2)); // R1
  AST_GATED_BEFORE_OFF: assert property (@(posedge clk_i) disable iff (rst_i) $fell(osc_en_o) |-> ($past(dom_clk_o) == '0) && !vco_en_o); // R3
  AST_LOW_WHILE_OFF: assert property (@(posedge clk_i) disable iff (rst_i) !osc_en_o |-> (dom_clk_o == '0)); // R4
  AST_VCO_NEEDS_OSC: assert property (@(posedge clk_i) disable iff (rst_i) vco_en_o |-> osc_en_o); // R5
  AST_VCO_LAGS_OSC: assert property (@(posedge clk_i) disable iff (rst_i) $rose(vco_en_o) |-> $past(osc_en_o)); // R5
  AST_SETTLE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i) (dom_clk_o != '0) |-> (since_wake == SMAX)); // R6

  for (genvar g = 0; g < N_DOM; g++) begin : g_pulse
    AST_FULL_PULSE: assert property (@(posedge clk_i) disable iff (rst_i) $rose(dom_clk_o[g]) |-> $past(dom_clk_i[g]) && !$past(dom_clk_i[g], 2)); // R2
  end
endmodule

bind clk_pwrdn_seq clk_pwrdn_seq_chk #(.N_DOM(N_DOM), .SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .pd_req_n_i(pd_req_n_i), .dom_clk_i(dom_clk_i),
  .dom_clk_o(dom_clk_o), .osc_en_o(osc_en_o), .vco_en_o(vco_en_o)
);

// File: tb/clk_pwrdn_seq_tb.sv
module clk_pwrdn_seq_tb;
  localparam int N   = 4;
  localparam int SET = 40;
  localparam int HMAX = 5;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         pd_n = 1'b1;
  logic [N-1:0] dclk = '0;
  logic [N-1:0] stop = '0;
  logic [N-1:0] dout;
  logic         osc_en, vco_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  clk_pwrdn_seq #(.N_DOM(N), .SETTLE_CYC(SET)) u_dut (
    .clk_i(clk), .rst_i(rst), .pd_req_n_i(pd_n), .dom_clk_i(dclk),
    .dom_stop_i(stop), .dom_clk_o(dout), .osc_en_o(osc_en), .vco_en_o(vco_en)
  );

  always #4 clk = ~clk;

  function automatic int half(int d);
    case (d)
      0: return 1;
      1: return 2;
      2: return 3;
      default: return HMAX;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // domain clock sources, driven away from the active edge
  int dcnt [N];
  initial for (int d = 0; d < N; d++) dcnt[d] = 0;
  always @(negedge clk) begin
    for (int d = 0; d < N; d++) begin
      if (dcnt[d] == half(d) - 1) begin
        dcnt[d] = 0;
        dclk[d] = ~dclk[d];
      end else dcnt[d]++;
    end
  end

  // scoreboard: expected enable transitions
  int exp_q [$];

  // monitor
  int  hi_len [N];
  int  rises [N];
  logic [N-1:0] prev_out = '0;
  logic prev_osc = 1'b1;
  bit  wake_armed = 0;
  int  wake_cnt = 0;
  bit  off_bad = 0;
  initial for (int d = 0; d < N; d++) begin hi_len[d] = 0; rises[d] = 0; end

  always @(negedge clk) begin
    if (rst) begin
      wake_armed = 1; wake_cnt = 0; prev_osc = 1'b1; prev_out = '0;
    end else begin
      for (int d = 0; d < N; d++) begin
        if (dout[d]) begin
          if (!prev_out[d]) rises[d]++;
          hi_len[d]++;
        end else if (hi_len[d] > 0) begin
          chk(hi_len[d] == half(d), "R2 pulse width", hi_len[d], half(d));
          hi_len[d] = 0;
        end
      end
      if (osc_en != prev_osc) begin
        if (exp_q.size() == 0) chk(0, "R5 unexpected enable change", osc_en, prev_osc);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(osc_en == e[0], "R5 enable sequence", osc_en, e);
        end
        if (!osc_en) begin
          chk(prev_out == '0 && dout == '0, "R3 gated before enables drop", prev_out, 0);
          chk(vco_en == 1'b0, "R3 vco drops with osc", vco_en, 0);
          wake_armed = 0;
        end else begin
          chk(vco_en == 1'b0, "R5 vco lags osc", vco_en, 0);
          chk(!off_bad, "R4 outputs low while off", off_bad, 0);
          off_bad = 0;
          wake_armed = 1; wake_cnt = 0;
        end
      end else if (!osc_en && dout != '0) off_bad = 1;
      if (wake_armed) begin
        if (dout != '0) begin
          chk(wake_cnt >= SET && wake_cnt <= SET + 2*HMAX + 8, "R6 settle window", wake_cnt, SET);
          wake_armed = 0;
        end else wake_cnt++;
      end
      prev_out = dout;
      prev_osc = osc_en;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int total_rises();
    int s = 0;
    for (int d = 0; d < N; d++) s += rises[d];
    return s;
  endfunction

  initial begin
    int r0, r2;
    cyc(5);
    chk(dout == '0, "R9 reset outputs low", dout, 0);
    chk(osc_en && vco_en, "R9 reset enables high", {osc_en, vco_en}, 3);
    rst = 1'b0;
    cyc(SET);
    chk(total_rises() == 0, "R9 settle after reset", total_rises(), 0);
    cyc(60);
    for (int d = 0; d < N; d++) chk(rises[d] > 0, "R2 domain running", rises[d], 1);

    // first power-down
    pd_n = 1'b0; exp_q.push_back(0);
    cyc(2);
    chk(osc_en == 1'b1, "R1 no action before sync", osc_en, 1);
    cyc(40);
    chk(osc_en == 1'b0 && vco_en == 1'b0, "R3 enables off", {osc_en, vco_en}, 0);
    chk(dout == '0, "R4 all outputs low", dout, 0);
    // local stops while powered down
    stop = '1;
    cyc(10);
    chk(osc_en == 1'b0 && dout == '0, "R7 stop ignored in power-down", dout, 0);
    stop = '0;
    cyc(10);
    chk(osc_en == 1'b0, "R7 still powered down", osc_en, 0);

    pd_n = 1'b1; exp_q.push_back(1);
    cyc(4);
    chk(osc_en == 1'b1, "R1 osc up after sync", osc_en, 1);
    cyc(1);
    chk(vco_en == 1'b1, "R5 vco up", vco_en, 1);
    r0 = total_rises();
    cyc(SET + 40);
    chk(total_rises() > r0, "R6 outputs resume", total_rises(), r0 + 1);

    // local stop while running
    stop[2] = 1'b1;
    cyc(20);
    r2 = rises[2]; r0 = rises[0];
    cyc(30);
    chk(rises[2] == r2 && dout[2] == 1'b0, "R7 stopped domain held low", rises[2], r2);
    chk(rises[0] > r0, "R7 other domain runs", rises[0], r0 + 1);
    stop[2] = 1'b0;
    cyc(30);
    chk(rises[2] > r2, "R7 domain restarts", rises[2], r2 + 1);

    // abort during settle
    pd_n = 1'b0; exp_q.push_back(0);
    cyc(40);
    r0 = total_rises();
    pd_n = 1'b1; exp_q.push_back(1);
    cyc(12);
    pd_n = 1'b0; exp_q.push_back(0);
    cyc(40);
    chk(total_rises() == r0, "R8 no pulse on aborted wake", total_rises(), r0);
    chk(osc_en == 1'b0, "R8 back in power-down", osc_en, 0);
    pd_n = 1'b1; exp_q.push_back(1);
    cyc(SET + 40);
    chk(total_rises() > r0, "R6 resume after abort", total_rises(), r0 + 1);
    chk(exp_q.size() == 0, "R5 all enable events seen", exp_q.size(), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule